// File: doc/BRIEF.md
# Debug Scan-Chain Selector

This block sits in the test-clock domain of an on-chip debug unit. It decides which internal debug scan chain receives later data-register scans. The TAP controller supplies the shift, pause and update strobes and a flag that says the debug instruction is active. The block samples TDI on each shift clock and drives TDO.

Each frame opens with a selector bit. When the selector is 1, the frame asks for a new chain. A 4-bit chain number follows, then a 32-bit checksum of the selector and the number. The block compares that checksum with its own, shifts out five status bits, and then shifts out a 32-bit checksum of those status bits, all before update-DR. The new chain takes effect at update-DR, and only if the frame was complete, the checksum matched and the number names an existing chain. When the selector is 0, the frame belongs to the chain already selected, and this block stays silent for it.

There are nine chain numbers, 0 to 8: the system-bus access chain, the register chain, four CPU debug chains, the CPU test chain, the trace test chain and the global boundary-scan chain. The value 4'hF means that no chain is selected.

Top module: `dbg_chain_sel`

## Requirements
- R1: After asynchronous reset (rst_ni low), chain_o reads 4'hF (no chain) and tdo_o is 0.
- R2: Frame bit positions, counted from the first shift-DR clock: bit 0 is the selector, bits 1..4 carry the chain number LSB first, and bits 5..36 carry the checksum MSB first. A frame with selector 1, a matching checksum and a number below 9 sets chain_o to that number on the clock that samples update_dr_i high, and not earlier.
- R3: The checksum is CRC-32 with polynomial 0x04C11DB7, starting value all ones and no final inversion. It is computed MSB-shifted over the selector and then the four number bits in shift order. On a mismatch chain_o keeps its old value.
- R4: Frame bits 37..41 shift out the status on tdo_o. The first bit out is 1 on a checksum mismatch and 0 otherwise. The other four bits (busy, bus error, overrun, reserved) read 0.
- R5: Frame bits 42..73 shift out, MSB first, the R3 CRC computed over the five status bits in their output order.
- R6: A frame with selector 0 leaves chain_o unchanged and holds tdo_o at 0 for the whole frame.
- R7: An update-DR that arrives before the last checksum bit (frame bit 36) has been shifted leaves chain_o unchanged.
- R8: Cycles with shift_dr_i low and pause_dr_i high keep the frame position, so a frame paused at any bit and then resumed gives the same status, returned checksum and selection as an unbroken frame.
- R9: While debug_sel_i is low, shift and update clocks are ignored, tdo_o is 0 and the frame position returns to bit 0.
- R10: A chain number of 9 to 15 is not latched, even when its checksum matches.
- R11: rst_ni low sets chain_o to 4'hF at once, without waiting for a clock edge, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous test reset, active low |
| tdi_i | input | 1 | Serial data in |
| shift_dr_i | input | 1 | TAP is in shift-DR |
| pause_dr_i | input | 1 | TAP is in pause-DR |
| update_dr_i | input | 1 | TAP is in update-DR |
| debug_sel_i | input | 1 | Debug instruction is active |
| tdo_o | output | 1 | Serial data out |
| chain_o | output | 4 | Selected chain number, 4'hF when none |

## Verification
A bad frame counter moves every field. The status bits and the returned checksum then come out on the wrong clocks, and the mismatch is visible within the same frame. A wrong input checksum register or a wrong compare shows up at once as a wrong first status bit. It also shows at the next update-DR as a chain_o that changed when it should have held, or held when it should have changed. Stale selector state shows as non-zero tdo_o during a selector-0 frame.

// File: rtl/dbg_cs_pkg.sv
`timescale 1ns/1ps
package dbg_cs_pkg;
  localparam int          CS_ID_W      = 4;
  localparam int          CS_CRC_W     = 32;
  localparam int          CS_STAT_W    = 5;
  localparam int          CS_NUM_CHAIN = 9;
  localparam logic [31:0] CS_POLY      = 32'h04C11DB7;

  typedef enum logic [2:0] {
    PH_SEL,
    PH_ID,
    PH_CRC,
    PH_STAT,
    PH_RCRC,
    PH_DONE
  } cs_phase_e;
endpackage

// File: rtl/dbg_cs_crc.sv
`timescale 1ns/1ps
module dbg_cs_crc #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         step_i,
  input  logic         bit_i,
  input  logic         shl_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_step;

  always_comb begin
    crc_step = {crc_q[W-2:0], 1'b0};
    if (crc_q[W-1] ^ bit_i) crc_step = crc_step ^ POLY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (step_i) crc_q <= crc_step;
    else if (shl_i)  crc_q <= {crc_q[W-2:0], 1'b0};
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/dbg_cs_frame.sv
`timescale 1ns/1ps
module dbg_cs_frame
  import dbg_cs_pkg::*;
#(
  parameter int ID_W   = CS_ID_W,
  parameter int CRC_W  = CS_CRC_W,
  parameter int STAT_W = CS_STAT_W,
  localparam int POS_CRC  = 1 + ID_W,
  localparam int POS_STAT = POS_CRC + CRC_W,
  localparam int POS_RCRC = POS_STAT + STAT_W,
  localparam int POS_END  = POS_RCRC + CRC_W,
  localparam int CNT_W    = $clog2(POS_END + 1),
  localparam int SIDX_W   = $clog2(STAT_W)
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  logic              shift_dr_i,
  input  logic              pause_dr_i,
  input  logic              update_dr_i,
  input  logic              debug_sel_i,
  output cs_phase_e         phase_o,
  output logic              shift_en_o,
  output logic              clr_o,
  output logic              sel_o,
  output logic [ID_W-1:0]   id_o,
  output logic [CRC_W-1:0]  crc_rx_o,
  output logic              last_crc_bit_o,
  output logic [SIDX_W-1:0] stat_idx_o
);
  localparam logic [CNT_W-1:0] P_CRC   = CNT_W'(POS_CRC);
  localparam logic [CNT_W-1:0] P_STAT  = CNT_W'(POS_STAT);
  localparam logic [CNT_W-1:0] P_RCRC  = CNT_W'(POS_RCRC);
  localparam logic [CNT_W-1:0] P_END   = CNT_W'(POS_END);
  localparam logic [CNT_W-1:0] P_LASTC = CNT_W'(POS_STAT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stat_off;

  assign shift_en_o = shift_dr_i & debug_sel_i;
  assign clr_o      = update_dr_i | ~debug_sel_i;

  always_comb begin
    if (cnt_q == '0)         phase_o = PH_SEL;
    else if (cnt_q < P_CRC)  phase_o = PH_ID;
    else if (cnt_q < P_STAT) phase_o = PH_CRC;
    else if (cnt_q < P_RCRC) phase_o = PH_STAT;
    else if (cnt_q < P_END)  phase_o = PH_RCRC;
    else                     phase_o = PH_DONE;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sel_o    <= 1'b0;
      id_o     <= '0;
      crc_rx_o <= '0;
    end else if (clr_o) begin
      cnt_q    <= '0;
      sel_o    <= 1'b0;
    end else if (shift_en_o) begin
      if (cnt_q != P_END)      cnt_q    <= cnt_q + 1'b1;
      if (phase_o == PH_SEL)   sel_o    <= tdi_i;
      if (phase_o == PH_ID)    id_o     <= {tdi_i, id_o[ID_W-1:1]};
      if (phase_o == PH_CRC)   crc_rx_o <= {crc_rx_o[CRC_W-2:0], tdi_i};
    end
  end

  assign last_crc_bit_o = (cnt_q == P_LASTC);
  assign stat_off       = cnt_q - P_STAT;
  assign stat_idx_o     = stat_off[SIDX_W-1:0];

  // R8: a pause cycle keeps the frame position
  a_r8_pause_holds: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (pause_dr_i && !shift_dr_i && !update_dr_i && debug_sel_i) |=> $stable(cnt_q));

  // R9: deselection sends the frame back to bit 0
  a_r9_deselect_clears: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !debug_sel_i |=> (phase_o == PH_SEL));
endmodule

// File: rtl/dbg_chain_sel.sv
`timescale 1ns/1ps
module dbg_chain_sel
  import dbg_cs_pkg::*;
#(
  parameter int          ID_W      = CS_ID_W,
  parameter int          CRC_W     = CS_CRC_W,
  parameter int          STAT_W    = CS_STAT_W,
  parameter int          NUM_CHAIN = CS_NUM_CHAIN,
  parameter logic [31:0] POLY      = CS_POLY,
  localparam int         SIDX_W    = $clog2(STAT_W)
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  logic            shift_dr_i,
  input  logic            pause_dr_i,
  input  logic            update_dr_i,
  input  logic            debug_sel_i,
  output logic            tdo_o,
  output logic [ID_W-1:0] chain_o
);
  localparam logic [ID_W-1:0] CHAIN_NONE = '1;
  localparam logic [ID_W-1:0] CHAIN_LIM  = ID_W'(NUM_CHAIN);

  cs_phase_e          phase;
  logic               shift_en, clr, sel, last_crc_bit;
  logic [ID_W-1:0]    id;
  logic [CRC_W-1:0]   crc_rx, crc_calc, crc_ret;
  logic [SIDX_W-1:0]  stat_idx;
  logic [STAT_W-1:0]  status;
  logic               stat_bit;
  logic               crc_err_q;
  logic               frame_ok;
  logic [ID_W-1:0]    chain_q;

  dbg_cs_frame #(.ID_W(ID_W), .CRC_W(CRC_W), .STAT_W(STAT_W)) u_frame (
    .tck_i          (tck_i),
    .rst_ni         (rst_ni),
    .tdi_i          (tdi_i),
    .shift_dr_i     (shift_dr_i),
    .pause_dr_i     (pause_dr_i),
    .update_dr_i    (update_dr_i),
    .debug_sel_i    (debug_sel_i),
    .phase_o        (phase),
    .shift_en_o     (shift_en),
    .clr_o          (clr),
    .sel_o          (sel),
    .id_o           (id),
    .crc_rx_o       (crc_rx),
    .last_crc_bit_o (last_crc_bit),
    .stat_idx_o     (stat_idx)
  );

  // checksum of selector and chain number, in shift order
  dbg_cs_crc #(.W(CRC_W), .POLY(CRC_W'(POLY))) u_crc_in (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .init_i (clr),
    .step_i (shift_en & (phase == PH_SEL || phase == PH_ID)),
    .bit_i  (tdi_i),
    .shl_i  (1'b0),
    .crc_o  (crc_calc)
  );

  // checksum of returned status, then shifted out MSB first
  dbg_cs_crc #(.W(CRC_W), .POLY(CRC_W'(POLY))) u_crc_out (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .init_i (clr),
    .step_i (shift_en & sel & (phase == PH_STAT)),
    .bit_i  (stat_bit),
    .shl_i  (shift_en & sel & (phase == PH_RCRC)),
    .crc_o  (crc_ret)
  );

  // status bit 0 = checksum error; busy, bus error, overrun, reserved read 0
  always_comb begin
    status    = '0;
    status[0] = crc_err_q;
  end
  assign stat_bit = status[stat_idx];

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          crc_err_q <= 1'b0;
    else if (clr)                         crc_err_q <= 1'b0;
    else if (shift_en && last_crc_bit)    crc_err_q <= ({crc_rx[CRC_W-2:0], tdi_i} != crc_calc);
  end

  always_comb begin
    tdo_o = 1'b0;
    if (debug_sel_i && sel) begin
      if (phase == PH_STAT)      tdo_o = stat_bit;
      else if (phase == PH_RCRC) tdo_o = crc_ret[CRC_W-1];
    end
  end

  assign frame_ok = sel && !crc_err_q && (id < CHAIN_LIM) &&
                    (phase == PH_STAT || phase == PH_RCRC || phase == PH_DONE);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                                  chain_q <= CHAIN_NONE;
    else if (update_dr_i && debug_sel_i && frame_ok) chain_q <= id;
  end

  assign chain_o = chain_q;

  // R2: selection moves only on an update clock
  a_r2_change_on_update: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_dr_i |=> $stable(chain_o));

  // R3: a failed checksum never changes the selection
  a_r3_bad_crc_holds: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_dr_i && crc_err_q) |=> $stable(chain_o));

  // R7: update before the checksum is complete has no effect
  a_r7_early_update_holds: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_dr_i && (phase == PH_SEL || phase == PH_ID || phase == PH_CRC)) |=> $stable(chain_o));

  // R6, R9: no output for command frames or when deselected
  a_r6_cmd_frame_quiet: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (debug_sel_i && !sel) |-> !tdo_o);
  a_r9_quiet_deselected: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !debug_sel_i |-> !tdo_o);

  // R10: only real chains or the none value are ever held
  always_comb begin
    if (rst_ni) a_r10_chain_legal: assert (chain_o < CHAIN_LIM || chain_o == CHAIN_NONE);
  end
endmodule

// File: tb/tb_dbg_chain_sel.sv
`timescale 1ns/1ps
module tb_dbg_chain_sel;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic tdi = 1'b0, shift_dr = 1'b0, pause_dr = 1'b0, update_dr = 1'b0, debug_sel = 1'b0;
  logic tdo_o;
  logic [3:0] chain_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_chain;

  always #10 tck = ~tck;

  dbg_chain_sel dut (
    .tck_i(tck), .rst_ni(rst_ni), .tdi_i(tdi), .shift_dr_i(shift_dr),
    .pause_dr_i(pause_dr), .update_dr_i(update_dr), .debug_sel_i(debug_sel),
    .tdo_o(tdo_o), .chain_o(chain_o)
  );

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
    crc_step = {c[30:0], 1'b0} ^ ((c[31] ^ b) ? POLY : 32'h0);
  endfunction

  function automatic logic [31:0] crc_req(input logic s, input logic [3:0] id);
    logic [31:0] c = 32'hFFFF_FFFF;
    c = crc_step(c, s);
    for (int k = 0; k < 4; k++) c = crc_step(c, id[k]);
    return c;
  endfunction

  function automatic logic [31:0] crc_ret(input logic [4:0] st);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 5; k++) c = crc_step(c, st[k]);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic sh, input logic pa, input logic up, input logic ds,
                      input logic b, output logic t);
    @(negedge tck);
    shift_dr = sh; pause_dr = pa; update_dr = up; debug_sel = ds; tdi = b;
    #1 t = tdo_o;
    @(posedge tck);
  endtask

  // shifts a whole 74-bit frame and goes to exit1; pause_at < 0 means no pause
  task automatic frame(input logic s, input logic [3:0] id, input logic [31:0] crc,
                       input int pause_at, input logic ds,
                       output logic [4:0] st, output logic [31:0] rc, output logic tdo_any);
    logic [36:0] v;
    logic t;
    v[0] = s;
    for (int k = 0; k < 4; k++) v[1+k] = id[k];
    for (int j = 0; j < 32; j++) v[5+j] = crc[31-j];
    st = '0; rc = '0; tdo_any = 1'b0;
    for (int i = 0; i < 74; i++) begin
      if (i == pause_at)
        for (int p = 0; p < 4; p++) tick(1'b0, 1'b1, 1'b0, ds, 1'b0, t);
      tick(1'b1, 1'b0, 1'b0, ds, (i < 37) ? v[i] : 1'b0, t);
      tdo_any |= t;
      if (i >= 37 && i < 42) st[i-37] = t;
      if (i >= 42) rc[31-(i-42)] = t;
    end
    tick(1'b0, 1'b0, 1'b0, ds, 1'b0, t);
  endtask

  task automatic do_update(input logic ds);
    logic t;
    tick(1'b0, 1'b0, 1'b1, ds, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, ds, 1'b0, t);
  endtask

  // full frame plus expected-value checks
  task automatic run_chk(input logic s, input logic [3:0] id, input logic bad,
                         input int pause_at, input string tag);
    logic [31:0] crc, rc;
    logic [4:0]  st;
    logic        any;
    logic [4:0]  exp_st;
    crc = crc_req(s, id);
    if (bad) crc = crc ^ (32'h1 << ($urandom % 32));
    frame(s, id, crc, pause_at, 1'b1, st, rc, any);
    chk({tag, " R2 unchanged before update"}, {28'h0, chain_o}, {28'h0, exp_chain});
    if (s) begin
      exp_st = {4'b0000, bad};
      chk({tag, " R4 status"}, {27'h0, st}, {27'h0, exp_st});
      chk({tag, " R5 returned crc"}, rc, crc_ret(exp_st));
    end else begin
      chk({tag, " R6 tdo quiet"}, {31'h0, any}, 32'h0);
    end
    do_update(1'b1);
    if (s && !bad && id < 4'd9) exp_chain = id;
    chk({tag, " chain after update"}, {28'h0, chain_o}, {28'h0, exp_chain});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic t;
    logic [4:0]  st;
    logic [31:0] rc;
    logic        any;
    void'($urandom(32'd4711));
    exp_chain = 4'hF;
    #35;
    chk("R1 reset chain", {28'h0, chain_o}, 32'hF);
    chk("R1 reset tdo", {31'h0, tdo_o}, 32'h0);
    rst_ni = 1'b1;

    run_chk(1'b1, 4'd3, 1'b0, -1, "R2 valid id3");
    run_chk(1'b1, 4'd5, 1'b1, -1, "R3 bad crc");
    run_chk(1'b0, 4'd1, 1'b0, -1, "R6 command frame");
    run_chk(1'b1, 4'd12, 1'b0, -1, "R10 id12");
    run_chk(1'b1, 4'd15, 1'b0, -1, "R10 id15");
    run_chk(1'b1, 4'd8, 1'b0, -1, "R2 id8");
    run_chk(1'b1, 4'd0, 1'b0, -1, "R2 id0");

    // R7: update after 20 bits of a valid frame
    begin
      logic [31:0] c = crc_req(1'b1, 4'd7);
      logic [36:0] v;
      v[0] = 1'b1;
      for (int k = 0; k < 4; k++) v[1+k] = 1'(4'd7 >> k);
      for (int j = 0; j < 32; j++) v[5+j] = c[31-j];
      for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 1'b0, 1'b1, v[i], t);
      tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, t);
      do_update(1'b1);
      chk("R7 early update", {28'h0, chain_o}, {28'h0, exp_chain});
    end

    run_chk(1'b1, 4'd6, 1'b0, 40, "R8 pause in status");
    run_chk(1'b1, 4'd4, 1'b0, 12, "R8 pause in crc");
    run_chk(1'b1, 4'd2, 1'b0, 60, "R8 pause in returned crc");

    // R9: whole frame while deselected
    frame(1'b1, 4'd1, crc_req(1'b1, 4'd1), -1, 1'b0, st, rc, any);
    do_update(1'b0);
    chk("R9 deselected tdo", {31'h0, any}, 32'h0);
    chk("R9 deselected chain", {28'h0, chain_o}, {28'h0, exp_chain});
    // R9: deselect mid-frame restarts framing
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, t);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, t);
    run_chk(1'b1, 4'd1, 1'b0, -1, "R9 restart after deselect");

    // random frames
    for (int n = 0; n < 60; n++) begin
      logic       s = ($urandom % 5) != 0;
      logic [3:0] id = (($urandom % 4) == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
      logic       bad = ($urandom % 3) == 0;
      int         pa = (($urandom % 4) == 0) ? int'($urandom % 74) : -1;
      run_chk(s, id, bad, pa, "rand");
    end

    // R11: asynchronous reset in mid-frame
    for (int i = 0; i < 30; i++) tick(1'b1, 1'b0, 1'b0, 1'b1, 1'($urandom), t);
    @(negedge tck);
    #3 rst_ni = 1'b0;
    #2 chk("R11 async reset chain", {28'h0, chain_o}, 32'hF);
    chk("R11 async reset tdo", {31'h0, tdo_o}, 32'h0);
    shift_dr = 1'b0; debug_sel = 1'b0;
    @(negedge tck);
    rst_ni = 1'b1;
    exp_chain = 4'hF;
    run_chk(1'b1, 4'd7, 1'b0, -1, "R11 after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule